// File: doc/BRIEF.md
# Interrupt Request Hold-Off Timer

This block sits on the path from a device's merged interrupt-pending condition to its external interrupt request line. Once the request line drops, the block keeps it low for a programmable quiet period before it may rise again, so that the host sees a limited interrupt rate. The quiet period is set in units of 10 microseconds. A free-running prescaler divides the clock into 10 microsecond ticks, and a down-counter measures out the period in those ticks.

Software programs the period through an 8-bit field in the upper byte of a 32-bit configuration write. Writing zero turns the hold-off off. The same write also cancels any countdown in progress, so a pending interrupt that is being held back appears on the line at once. A power-management wake event never waits for the hold-off and drives the request line directly.

Top module: `irq_holdoff_top`

## Requirements
- R1: During and after reset the request line and the running-status output are low and the stored interval is zero, so no hold-off applies until a write sets one.
- R2: One tick occurs every TICK_CYCLES clocks from a prescaler that runs from reset. With a stored interval N, the running-status output stays high for between (N-1)*TICK_CYCLES+1 and N*TICK_CYCLES clocks after the request line falls.
- R3: While the running-status output is high, an ordinary pending interrupt does not raise the request line.
- R4: When the running-status output is low and an ordinary interrupt is pending, the request line is high after the next clock edge.
- R5: On the clock edge where the request line falls, the counter loads the stored interval. A write sets the stored interval from bits 31:24 of the write data. A stored interval of zero gives no hold-off.
- R6: A write whose bits 31:24 are zero clears the counter at the next edge. Running-status is then low, and any pending ordinary interrupt is on the request line after that same edge.
- R7: A non-zero write made while a countdown runs leaves the current countdown unchanged. The new value is used from the next fall of the request line.
- R8: An asserted wake event raises the request line at the next clock edge, whatever the counter state.
- R9: With both the wake event and the ordinary pending input low, the request line is low after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pending_i | input | 1 | Merged ordinary interrupt-pending condition |
| wake_event_i | input | 1 | Power-management wake event, bypasses the hold-off |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data; interval field in bits 31:24 |
| irq_o | output | 1 | Interrupt request line, active high |
| holdoff_active_o | output | 1 | High while the hold-off countdown is running |

## Verification
The assertions check the single-cycle rules on every clock edge. These are the blocking of ordinary interrupts while the hold-off runs, the immediate release on a zero write, the wake bypass, the assertion once the counter is idle, the drop when nothing is pending, and the counter load when the line falls. Only the bench's scenarios can show the length of a countdown in clocks and the prescaler phase behind it. The same holds for the rule that a non-zero write in the middle of a countdown changes only the following countdown. The bench covers these with a cycle-accurate expected-value model under random traffic and with directed measurements of the hold-off window.

// File: rtl/irq_holdoff_pkg.sv
package irq_holdoff_pkg;

    localparam int CFG_W      = 32;
    localparam int IVL_W      = 8;
    localparam int IVL_LSB    = 24;

    typedef logic [IVL_W-1:0] ivl_t;

    typedef struct packed {
        ivl_t ivl;
        logic irq;
    } ctl_state_t;

    function automatic ivl_t ivl_field(input logic [CFG_W-1:0] w);
        return w[IVL_LSB +: IVL_W];
    endfunction

endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
    parameter int TICK_CYCLES = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] presc_d, presc_q;
    logic          wrap;

    generate
        if (TICK_CYCLES > 1) begin : g_div
            assign wrap = (presc_q == LAST);
        end else begin : g_pass
            assign wrap = 1'b1;
        end
    endgenerate

    always_comb begin
        presc_d = wrap ? '0 : presc_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) presc_q <= '0;
        else         presc_q <= presc_d;
    end

    assign tick_o = wrap;
endmodule

// File: rtl/irq_holdoff_counter.sv
module irq_holdoff_counter
    import irq_holdoff_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic clear_i,
    input  logic load_i,
    input  ivl_t load_val_i,
    output logic idle_o
);
    ivl_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/irq_holdoff_top.sv
module irq_holdoff_top
    import irq_holdoff_pkg::*;
#(
    parameter int TICK_CYCLES = 1000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             irq_pending_i,
    input  logic             wake_event_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             irq_o,
    output logic             holdoff_active_o
);
    ctl_state_t st_d, st_q;
    ivl_t       interval_q;
    logic       tick;
    logic       cnt_idle;
    logic       zero_wr;
    logic       load;

    irq_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    always_comb begin
        st_d    = st_q;
        zero_wr = cfg_wr_i && (ivl_field(cfg_wdata_i) == '0);
        if (cfg_wr_i) begin
            st_d.ivl = ivl_field(cfg_wdata_i);
        end
        st_d.irq = wake_event_i || (irq_pending_i && (cnt_idle || zero_wr));
        load     = st_q.irq && !st_d.irq;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign interval_q = st_q.ivl;

    irq_holdoff_counter u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .clear_i    (zero_wr),
        .load_i     (load),
        .load_val_i (interval_q),
        .idle_o     (cnt_idle)
    );

    assign irq_o            = st_q.irq;
    assign holdoff_active_o = !cnt_idle;
endmodule

// File: rtl/irq_holdoff_chk.sv
module irq_holdoff_chk
    import irq_holdoff_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             irq_pending_i,
    input logic             wake_event_i,
    input logic             cfg_wr_i,
    input logic [CFG_W-1:0] cfg_wdata_i,
    input logic             irq_o,
    input logic             holdoff_active_o,
    input ivl_t             interval_i
);
    logic zw;
    assign zw = cfg_wr_i && (cfg_wdata_i[IVL_LSB +: IVL_W] == '0);

    AST_HOLD_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (holdoff_active_o && !wake_event_i && !zw) |=> !irq_o); // R3

    AST_IDLE_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_pending_i && !holdoff_active_o) |=> irq_o); // R4

    AST_LOAD_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !wake_event_i && !irq_pending_i && !zw && (interval_i != '0))
        |=> (holdoff_active_o && !irq_o)); // R5

    AST_ZERO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zw |=> !holdoff_active_o); // R6

    AST_ZERO_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (zw && irq_pending_i) |=> irq_o); // R6

    AST_WAKE_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_event_i |=> irq_o); // R8

    AST_QUIET_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wake_event_i && !irq_pending_i) |=> !irq_o); // R9

    always_comb begin
        if (!rst_ni) begin
            AST_RESET_LOW: assert (!irq_o && !holdoff_active_o); // R1
        end
    end
endmodule

bind irq_holdoff_top irq_holdoff_chk u_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .irq_pending_i    (irq_pending_i),
    .wake_event_i     (wake_event_i),
    .cfg_wr_i         (cfg_wr_i),
    .cfg_wdata_i      (cfg_wdata_i),
    .irq_o            (irq_o),
    .holdoff_active_o (holdoff_active_o),
    .interval_i       (interval_q)
);

// File: tb/test_irq_holdoff_top.sv
module test_irq_holdoff_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICKS      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pend = 1'b0;
    logic        wake = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        irq;
    logic        active;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    // expected-value model state
    int m_presc, m_cnt, m_ivl;
    bit m_irq;

    irq_holdoff_top #(.TICK_CYCLES(TICKS)) i_irq_holdoff_top (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .irq_pending_i    (pend),
        .wake_event_i     (wake),
        .cfg_wr_i         (wr),
        .cfg_wdata_i      (wdata),
        .irq_o            (irq),
        .holdoff_active_o (active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    function automatic int next_cnt(int cnt, int ivl, bit tick, bit zw, bit ld);
        if (zw) return 0;
        if (ld) return ivl;
        if (tick && cnt != 0) return cnt - 1;
        return cnt;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one clock with given inputs; model advances in step; compare after edge
    task automatic step(bit p, bit w, bit we, logic [31:0] d, string req);
        bit tick, zw, nirq, ld;
        pend = p; wake = w; wr = we; wdata = d;
        tick = (m_presc == TICKS - 1);
        zw   = we && (d[31:24] == 8'd0);
        nirq = w || (p && (m_cnt == 0 || zw));
        ld   = m_irq && !nirq;
        m_cnt   = next_cnt(m_cnt, m_ivl, tick, zw, ld);
        m_presc = tick ? 0 : m_presc + 1;
        if (we) m_ivl = int'(d[31:24]);
        m_irq = nirq;
        @(posedge clk);
        #1;
        check(req, "irq", int'(irq), int'(m_irq));
        check(req, "active", int'(active), int'(m_cnt != 0));
    endtask

    task automatic idle(int n, bit p, string req);
        for (int i = 0; i < n; i++) step(p, 1'b0, 1'b0, 32'h0, req);
    endtask

    initial begin
        int len;
        m_presc = 0; m_cnt = 0; m_ivl = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "irq in reset", int'(irq), 0);
        check("R1", "active in reset", int'(active), 0);
        rst_n = 1'b1;

        // R1: stored interval is zero after reset -> no hold-off after a fall
        step(1, 0, 0, 0, "R4");
        step(0, 0, 0, 0, "R9");
        check("R1", "no hold-off with reset interval", int'(active), 0);
        step(1, 0, 0, 0, "R1");
        check("R4", "raise when idle", int'(irq), 1);

        // R5/R2: program 3, measure the window
        step(1, 0, 1, 32'h03AB_CDEF, "R5");
        step(0, 0, 0, 0, "R9");
        check("R5", "load on fall", int'(active), 1);
        len = 1;
        while (active && len < 100) begin
            step(1, 0, 0, 0, "R3");
            if (active) len++;
        end
        n_checks++;
        if (len < 2*TICKS + 1 || len > 3*TICKS) begin
            n_errs++;
            $display("FAIL R2 window length: actual=%0d expected=%0d..%0d", len, 2*TICKS+1, 3*TICKS);
        end
        step(1, 0, 0, 0, "R4");
        check("R4", "raise after window", int'(irq), 1);

        // R6: zero write releases held interrupt
        step(0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, "R3");
        check("R3", "held while active", int'(irq), 0);
        step(1, 0, 1, 32'h00FF_FFFF, "R6");
        check("R6", "release on zero write", int'(irq), 1);
        check("R6", "counter cleared", int'(active), 0);

        // R7: rewrite during countdown
        step(1, 0, 1, 32'h0200_0000, "R5");
        step(0, 0, 0, 0, "R9");
        step(0, 0, 1, 32'h0900_0000, "R7");
        len = 2;
        while (active && len < 100) begin
            step(0, 0, 0, 0, "R7");
            if (active) len++;
        end
        n_checks++;
        if (len > 2*TICKS) begin
            n_errs++;
            $display("FAIL R7 old window kept: actual=%0d expected<=%0d", len, 2*TICKS);
        end
        step(1, 0, 0, 0, "R4");
        step(0, 0, 0, 0, "R7");
        len = 1;
        while (active && len < 200) begin
            step(0, 0, 0, 0, "R7");
            if (active) len++;
        end
        n_checks++;
        if (len < 8*TICKS + 1 || len > 9*TICKS) begin
            n_errs++;
            $display("FAIL R7 new window used: actual=%0d expected=%0d..%0d", len, 8*TICKS+1, 9*TICKS);
        end

        // R8: wake during hold-off
        step(1, 0, 0, 0, "R4");
        step(0, 0, 0, 0, "R9");
        check("R8", "hold-off running before wake", int'(active), 1);
        step(1, 1, 0, 0, "R8");
        check("R8", "wake bypasses hold-off", int'(irq), 1);
        step(1, 0, 0, 0, "R3");
        idle(60, 1'b0, "R2");

        // random traffic against the model
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            bit p, w, we;
            logic [31:0] d;
            p  = ($urandom % 4) != 0;
            w  = ($urandom % 40) == 0;
            we = ($urandom % 60) == 0;
            d  = ($urandom % 4 == 0) ? 32'h0 : {8'($urandom % 6), 24'($urandom)};
            step(p, w, we, d, "R2");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule